// File: doc/BRIEF.md
# Multiprocessor Bus Arbiter with Reset Control

This block decides which of up to four processors owns a shared processor bus. Each processor has a request/grant pair. After reset only pairs 0 and 1 compete for the bus, and processors 2 and 3 are held in hard and soft reset. Software sets one mode bit to open arbitration to all four pairs. The same bit releases the extra processors from reset. Among eligible requesters the grant rotates round-robin. The owner keeps the grant until it pulses end of tenure. A processor that already has two pipelined transactions in flight is skipped until one of them completes.

A small register port gives software control of the mode and of the hard- and soft-reset lines of processors 2 and 3, which it can later reassert. A read-only register reports the current bus owner. Errors arrive as a tagged one-cycle pulse and latch one of two machine-check sources. Each source drives a pair of active-low machine-check outputs: one source serves processors 0 and 2, the other serves processors 1 and 3. A source stays set until software clears it.

Top module: `mp_bus_arbiter`

## Requirements
- R1: After reset no grant is driven, all four machine-check outputs are high, and the hard- and soft-reset outputs of processors 2 and 3 are low. Reads return 0 from CTRL, 0 from PID and 3 from both HRST and SRST.
- R2: While CTRL bit 0 (four-way enable) is 0, requests on pairs 2 and 3 never produce a grant, and clearing the bit does not reassert any reset.
- R3: A write to CTRL (address 0) that changes bit 0 from 0 to 1 clears HRST and SRST on the same edge, which drives all four reset outputs high.
- R4: HRST (address 1) bit k and SRST (address 2) bit k hold processor 2+k in reset. A 1 drives `hrst_n_o[k]` or `srst_n_o[k]` low, and the register reads back the written value.
- R5: A grant goes to an eligible requester on the edge after the bus is idle. The search starts at the pair after the last owner, wraps around, and gives pair 0 the first turn after reset.
- R6: A grant is held, whatever the requests do, until `done_i` is sampled high. The grant then drops for at least one cycle before the next grant.
- R7: A processor with two granted transactions not yet completed through `xact_cmpl_i` is not granted. It becomes eligible again on the edge after a completion pulse.
- R8: PID (address 4) returns the index of the current or last bus owner in bits 7:0 (0x00 to 0x03, pair 0 to 3), with all upper bits 0.
- R9: An `err_valid_i` pulse tagged to processor 0 or 2 sets machine-check source 0, which drives `mchk_n_o[0]` and `mchk_n_o[2]` low. A pulse tagged to processor 1 or 3 sets source 1, which drives `mchk_n_o[1]` and `mchk_n_o[3]` low.
- R10: A machine-check source stays set until a write of 1 to its bit in MCHK (address 5; bit 0 is source 0, bit 1 is source 1). An error on the same edge as the clear keeps the source set. MCHK reads back the two source bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 4 | Bus request per pair |
| gnt_o | output | 4 | Bus grant per pair, one-hot or zero |
| done_i | input | 1 | End-of-tenure pulse from the current owner |
| xact_cmpl_i | input | 4 | Per-processor transaction completion pulse |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data, combinational from address |
| err_valid_i | input | 1 | Error event pulse |
| err_proc_i | input | 2 | Processor the error is tagged to |
| hrst_n_o | output | 2 | Active-low hard reset of processors 2 and 3 |
| srst_n_o | output | 2 | Active-low soft reset of processors 2 and 3 |
| mchk_n_o | output | 4 | Active-low machine check per processor |

## Verification
The hardest state to reach from the ports is a requester that is skipped only because its pipeline is full, while its request stays asserted and the bus sits idle. The stimulus grants processor 0 twice and ends both tenures without any completion. It then checks that the idle bus stays ungranted across several cycles. Next it pulses a single completion and confirms that the grant returns exactly one edge later. Round-robin rotation is walked from a vector table that covers wrap-around and skipped pairs.

// File: rtl/mpa_pkg.sv
package mpa_pkg;
  typedef enum logic [2:0] {
    A_CTRL = 3'd0,
    A_HRST = 3'd1,
    A_SRST = 3'd2,
    A_PID  = 3'd4,
    A_MCHK = 3'd5
  } reg_addr_e;
endpackage

// File: rtl/mpa_pipe_cnt.sv
module mpa_pipe_cnt #(
  parameter int N_PROC   = 4,
  parameter int PIPE_MAX = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_PROC-1:0] inc_i,
  input  logic [N_PROC-1:0] dec_i,
  output logic [N_PROC-1:0] full_o
);
  localparam int CW = $clog2(PIPE_MAX + 1);

  for (genvar i = 0; i < N_PROC; i++) begin : g_cnt
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) cnt_q <= '0;
      else if (inc_i[i] && !dec_i[i]) cnt_q <= cnt_q + CW'(1);
      else if (dec_i[i] && !inc_i[i] && cnt_q != '0) cnt_q <= cnt_q - CW'(1);
    end

    assign full_o[i] = (cnt_q >= CW'(PIPE_MAX));

    // R7
    cnt_max_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cnt_q <= CW'(PIPE_MAX));
    // R7
    no_inc_full_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      full_o[i] |-> !inc_i[i]);
  end
endmodule

// File: rtl/mpa_rr_arb.sv
module mpa_rr_arb #(
  parameter int N_PROC = 4,
  parameter int N_BASE = 2,
  localparam int IW = $clog2(N_PROC)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_PROC-1:0] req_i,
  input  logic [N_PROC-1:0] full_i,
  input  logic              four_way_i,
  input  logic              done_i,
  output logic [N_PROC-1:0] gnt_o,
  output logic [N_PROC-1:0] take_o,
  output logic [IW-1:0]     owner_o
);
  logic [N_PROC-1:0] elig, gnt_q;
  logic [IW-1:0]     last_q, owner_q, pick_idx, cand;
  logic              busy_q, found;

  always_comb begin
    elig = req_i & ~full_i;
    for (int i = N_BASE; i < N_PROC; i++)
      if (!four_way_i) elig[i] = 1'b0;
  end

  // rotate search start to the pair after the last owner
  always_comb begin
    found    = 1'b0;
    pick_idx = last_q;
    cand     = last_q;
    for (int k = 1; k <= N_PROC; k++) begin
      cand = IW'((int'(last_q) + k) % N_PROC);
      if (!found && elig[cand]) begin
        found    = 1'b1;
        pick_idx = cand;
      end
    end
  end

  always_comb begin
    take_o = '0;
    if (!busy_q && found) take_o[pick_idx] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gnt_q   <= '0;
      busy_q  <= 1'b0;
      last_q  <= IW'(N_PROC - 1);
      owner_q <= '0;
    end else if (!busy_q && found) begin
      gnt_q   <= take_o;
      busy_q  <= 1'b1;
      last_q  <= pick_idx;
      owner_q <= pick_idx;
    end else if (busy_q && done_i) begin
      gnt_q  <= '0;
      busy_q <= 1'b0;
    end
  end

  assign gnt_o   = gnt_q;
  assign owner_o = owner_q;

  // R5
  gnt_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(gnt_q));
  // R6
  gnt_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && !done_i) |=> $stable(gnt_q));
  // R6
  gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && done_i) |=> (gnt_q == '0));
  // R2
  two_way_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_q && !four_way_i) |=> (gnt_q[N_PROC-1:N_BASE] == '0));
endmodule

// File: rtl/mpa_regs.sv
module mpa_regs
  import mpa_pkg::*;
#(
  parameter int N_PROC = 4,
  parameter int N_BASE = 2,
  parameter int DW     = 32,
  localparam int IW    = $clog2(N_PROC),
  localparam int N_EXT = N_PROC - N_BASE
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [2:0]        addr_i,
  input  logic [DW-1:0]     wdata_i,
  output logic [DW-1:0]     rdata_o,
  input  logic [IW-1:0]     owner_i,
  input  logic              err_valid_i,
  input  logic [IW-1:0]     err_proc_i,
  output logic              four_way_o,
  output logic [N_EXT-1:0]  hrst_n_o,
  output logic [N_EXT-1:0]  srst_n_o,
  output logic [N_PROC-1:0] mchk_n_o
);
  logic              four_way_q;
  logic [N_EXT-1:0]  hrst_q, srst_q;
  logic [N_BASE-1:0] src_q, src_set, src_clr;
  logic              wr_ctrl, wr_hrst, wr_srst, wr_mchk, enable_rise;

  assign wr_ctrl     = we_i && (addr_i == A_CTRL);
  assign wr_hrst     = we_i && (addr_i == A_HRST);
  assign wr_srst     = we_i && (addr_i == A_SRST);
  assign wr_mchk     = we_i && (addr_i == A_MCHK);
  assign enable_rise = wr_ctrl && wdata_i[0] && !four_way_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      four_way_q <= 1'b0;
      hrst_q     <= '1;
      srst_q     <= '1;
    end else begin
      if (wr_ctrl) four_way_q <= wdata_i[0];
      if (enable_rise) begin
        hrst_q <= '0;
        srst_q <= '0;
      end else begin
        if (wr_hrst) hrst_q <= wdata_i[N_EXT-1:0];
        if (wr_srst) srst_q <= wdata_i[N_EXT-1:0];
      end
    end
  end

  always_comb begin
    src_set = '0;
    if (err_valid_i) src_set[int'(err_proc_i) % N_BASE] = 1'b1;
    src_clr = wr_mchk ? wdata_i[N_BASE-1:0] : '0;
  end

  // set wins over a same-edge clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) src_q <= '0;
    else         src_q <= (src_q & ~src_clr) | src_set;
  end

  for (genvar p = 0; p < N_PROC; p++) begin : g_mchk
    assign mchk_n_o[p] = ~src_q[p % N_BASE];
  end

  assign four_way_o = four_way_q;
  assign hrst_n_o   = ~hrst_q;
  assign srst_n_o   = ~srst_q;

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      A_CTRL:  rdata_o = DW'(four_way_q);
      A_HRST:  rdata_o = DW'(hrst_q);
      A_SRST:  rdata_o = DW'(srst_q);
      A_PID:   rdata_o = DW'(owner_i);
      A_MCHK:  rdata_o = DW'(src_q);
      default: rdata_o = '0;
    endcase
  end

  // R3
  rst_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    enable_rise |=> (hrst_n_o == '1 && srst_n_o == '1));
  // R2
  no_reassert_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_hrst && !wr_srst) |=> ($past(hrst_n_o) & ~hrst_n_o) == '0);
  // R10
  mck_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (src_q[0] && !(wr_mchk && wdata_i[0])) |=> src_q[0]);
  // R9
  mck_pair_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mchk_n_o[N_BASE-1:0] == mchk_n_o[N_PROC-1:N_BASE]);
endmodule

// File: rtl/mp_bus_arbiter.sv
module mp_bus_arbiter #(
  parameter int N_PROC   = 4,
  parameter int N_BASE   = 2,
  parameter int PIPE_MAX = 2,
  parameter int DW       = 32,
  localparam int IW      = $clog2(N_PROC),
  localparam int N_EXT   = N_PROC - N_BASE
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_PROC-1:0] req_i,
  output logic [N_PROC-1:0] gnt_o,
  input  logic              done_i,
  input  logic [N_PROC-1:0] xact_cmpl_i,
  input  logic              reg_we_i,
  input  logic [2:0]        reg_addr_i,
  input  logic [DW-1:0]     reg_wdata_i,
  output logic [DW-1:0]     reg_rdata_o,
  input  logic              err_valid_i,
  input  logic [IW-1:0]     err_proc_i,
  output logic [N_EXT-1:0]  hrst_n_o,
  output logic [N_EXT-1:0]  srst_n_o,
  output logic [N_PROC-1:0] mchk_n_o
);
  logic [N_PROC-1:0] full, take;
  logic [IW-1:0]     owner;
  logic              four_way;

  mpa_rr_arb #(.N_PROC(N_PROC), .N_BASE(N_BASE)) u_arb (
    .clk_i, .rst_ni, .req_i, .full_i(full), .four_way_i(four_way),
    .done_i, .gnt_o, .take_o(take), .owner_o(owner)
  );

  mpa_pipe_cnt #(.N_PROC(N_PROC), .PIPE_MAX(PIPE_MAX)) u_cnt (
    .clk_i, .rst_ni, .inc_i(take), .dec_i(xact_cmpl_i), .full_o(full)
  );

  mpa_regs #(.N_PROC(N_PROC), .N_BASE(N_BASE), .DW(DW)) u_regs (
    .clk_i, .rst_ni, .we_i(reg_we_i), .addr_i(reg_addr_i),
    .wdata_i(reg_wdata_i), .rdata_o(reg_rdata_o), .owner_i(owner),
    .err_valid_i, .err_proc_i, .four_way_o(four_way),
    .hrst_n_o, .srst_n_o, .mchk_n_o
  );
endmodule

// File: tb/mp_bus_arbiter_tb.sv
`timescale 1ns/1ps
module mp_bus_arbiter_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  req, gnt, cmpl, mchk_n;
  logic        done, we, err_v;
  logic [2:0]  addr;
  logic [31:0] wdata, rdata;
  logic [1:0]  err_p, hrst_n, srst_n;
  int          n_tests = 0, n_fail = 0;
  bit          finished = 0;

  always #2.5 clk = ~clk;

  mp_bus_arbiter dut_i (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .gnt_o(gnt), .done_i(done),
    .xact_cmpl_i(cmpl), .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .err_valid_i(err_v), .err_proc_i(err_p),
    .hrst_n_o(hrst_n), .srst_n_o(srst_n), .mchk_n_o(mchk_n)
  );

  // round-robin walk in four-way mode: {req, expected grant}
  localparam logic [7:0] VEC [8] = '{
    {4'b1111, 4'b0001}, {4'b1111, 4'b0010}, {4'b1001, 4'b1000},
    {4'b1001, 4'b0001}, {4'b0100, 4'b0100}, {4'b0011, 4'b0001},
    {4'b1010, 4'b0010}, {4'b1010, 4'b1000}
  };

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    we = 1'b1; addr = a; wdata = d;
    tick();
    we = 1'b0; wdata = '0;
  endtask

  task automatic grant_vec(input logic [3:0] r, input logic [3:0] e, input string tag);
    logic [31:0] d;
    int idx = 0;
    for (int i = 0; i < 4; i++) if (e[i]) idx = i;
    req = r;
    tick();
    chk({tag, " R5 grant"}, 32'(gnt), 32'(e));
    rd(3'd4, d);
    chk({tag, " R8 pid"}, d, 32'(idx));
    req = '0; done = 1'b1; cmpl = e;
    tick();
    done = 1'b0; cmpl = '0;
    chk({tag, " R6 release"}, 32'(gnt), 32'h0);
  endtask

  initial begin
    logic [31:0] d;
    req = '0; done = 0; cmpl = '0; we = 0; addr = '0; wdata = '0; err_v = 0; err_p = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;

    // R1 reset state
    chk("R1 gnt", 32'(gnt), 0);
    chk("R1 hrst_n", 32'(hrst_n), 0);
    chk("R1 srst_n", 32'(srst_n), 0);
    chk("R1 mchk_n", 32'(mchk_n), 32'hf);
    rd(3'd0, d); chk("R1 ctrl", d, 0);
    rd(3'd4, d); chk("R1 pid", d, 0);
    rd(3'd1, d); chk("R1 hrst reg", d, 3);
    rd(3'd2, d); chk("R1 srst reg", d, 3);

    // R2 pairs 2/3 ignored in two-way mode
    req = 4'b1100;
    repeat (4) tick();
    chk("R2 two-way ignore", 32'(gnt), 0);
    req = '0;

    // R3 enable four-way releases resets
    wr(3'd0, 1);
    chk("R3 hrst_n", 32'(hrst_n), 32'h3);
    chk("R3 srst_n", 32'(srst_n), 32'h3);
    rd(3'd0, d); chk("R3 ctrl", d, 1);

    for (int v = 0; v < 8; v++)
      grant_vec(VEC[v][7:4], VEC[v][3:0], $sformatf("vec%0d", v));

    // R6 hold until done, then one idle cycle
    req = 4'b0010;
    tick();
    chk("R6 grant", 32'(gnt), 32'h2);
    req = 4'b1111;
    repeat (3) begin tick(); chk("R6 hold", 32'(gnt), 32'h2); end
    req = 4'b0010; done = 1'b1;
    tick(); done = 1'b0;
    chk("R6 gap", 32'(gnt), 0);
    tick();
    chk("R6 regrant", 32'(gnt), 32'h2);
    req = '0; done = 1'b1; cmpl = 4'b0010;
    tick(); done = 1'b0;
    tick(); cmpl = '0;
    tick();

    // R7 pipeline depth limit
    req = 4'b0001;
    tick(); chk("R7 first", 32'(gnt), 1);
    done = 1; tick(); done = 0;
    tick(); chk("R7 second", 32'(gnt), 1);
    done = 1; tick(); done = 0;
    tick(); chk("R7 full blocks", 32'(gnt), 0);
    tick(); chk("R7 full blocks", 32'(gnt), 0);
    cmpl = 4'b0001; tick(); cmpl = '0;
    chk("R7 after cmpl", 32'(gnt), 0);
    tick(); chk("R7 regrant", 32'(gnt), 1);
    req = '0; done = 1; cmpl = 4'b0001; tick(); done = 0;
    tick(); cmpl = '0;
    tick();

    // R2 clearing mode bit: pairs 2/3 ignored, resets not reasserted
    wr(3'd0, 0);
    req = 4'b0100;
    repeat (3) tick();
    chk("R2 mode cleared", 32'(gnt), 0);
    chk("R2 no reassert", 32'(hrst_n), 32'h3);
    req = '0;

    // R4 reset registers
    wr(3'd1, 32'h2);
    chk("R4 hrst_n", 32'(hrst_n), 32'h1);
    rd(3'd1, d); chk("R4 hrst reg", d, 2);
    wr(3'd2, 32'h1);
    chk("R4 srst_n", 32'(srst_n), 32'h2);
    wr(3'd0, 1);
    chk("R3 re-enable hrst_n", 32'(hrst_n), 32'h3);
    chk("R3 re-enable srst_n", 32'(srst_n), 32'h3);

    // R9 machine-check pairing
    err_v = 1; err_p = 2'd2; tick(); err_v = 0;
    chk("R9 src0 pair", 32'(mchk_n), 32'ha);
    rd(3'd5, d); chk("R10 mchk reg", d, 1);
    // R10 sticky, clear, set-wins
    tick(); tick();
    chk("R10 sticky", 32'(mchk_n), 32'ha);
    err_v = 1; err_p = 2'd3; we = 1; addr = 3'd5; wdata = 32'h1;
    tick(); err_v = 0; we = 0;
    chk("R9 src1 pair / R10 clear", 32'(mchk_n), 32'h5);
    err_v = 1; err_p = 2'd1; we = 1; addr = 3'd5; wdata = 32'h2;
    tick(); err_v = 0; we = 0;
    chk("R10 set wins", 32'(mchk_n), 32'h5);
    wr(3'd5, 32'h2);
    chk("R10 cleared", 32'(mchk_n), 32'hf);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog act=timeout exp=done");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule